// File: doc/BRIEF.md
# OTP Bank Read Controller

This block fetches one-time-programmable fuse contents a bank at a time and presents them to software through registers. The fuse store holds 128 bytes, organised as 8 banks of four 32-bit words. Here it is modelled as a constant image computed from a parameter. Software picks a bank by writing its bit address, then sets a start bit in the control register. It polls a sticky done flag and afterwards reads the four words of that bank from a separate read-only data window.

Each word is fetched in a number of clock cycles set by an 8-bit period field in the control register. The period value in the write that starts the read applies to the whole fetch. The block also has control bits for CRC checking, secure-data loading, key selection and trim. These bits are stored and read back but have no effect. A small state machine drives the fetch:

- States: `ST_IDLE`, `ST_FETCH` and `ST_FINISH`.
- Idle to fetch: taken on an accepted start.
- Fetch to fetch: taken on each word boundary except the last.
- Fetch to finish: taken when the fourth word is latched.
- Finish to idle: sets done and clears the start bit.

Register offsets in the control/status space: control at 0x48, status at 0x4C, read address at 0x50. The data window has words 0 to 3 at 0x20, 0x24, 0x28 and 0x2C.

Top module: `otp_bank_reader`

## Requirements
- R1: After reset the control, status and address registers, and all four data-window words, read zero, and the busy flag (status bit 0) is clear.
- R2: Control bits 15:8 (period) and bits 5, 4, 3, 1, 0 are plain storage that reads back as written. Bits 7:6 and 31:16 read zero. Writing them without bit 2 starts nothing.
- R3: Writing the control register with bit 2 set while idle starts a fetch. Until the fetch ends, status bit 0 (busy) and control bit 2 both read 1.
- R4: With period P in the starting write, the fetch takes 4(P+1) cycles. Done (status bit 4) reads 1 exactly 4(P+1)+1 clock edges after the edge that accepted the start. On that same edge busy and control bit 2 return to 0.
- R5: While busy, a further write with bit 2 set is ignored: the fetch is not restarted and its timing still follows the period of the original start.
- R6: For address n*128 with n below 8, window word w (offset 0x20+4w) holds the bank's bytes. Byte k of that word sits in bits 8k+7:8k and equals (16n+4w+k) XOR the seed parameter (default 0x5A), taken to 8 bits.
- R7: An address of 1024 or more, or one that is not a multiple of 128, loads zero into all four window words and still sets done after the normal fetch time.
- R8: Done and the load-secure-done flag (status bit 2) are sticky. Writing 0 to the bit clears it, writing 1 leaves it unchanged, and software cannot set either one.
- R9: Window offsets other than the four word offsets, and unmapped register offsets, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write byte offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 8 | Register read byte offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| win_rd_addr | input | 8 | Data window read byte offset |
| win_rd_data | output | 32 | Data window read data (combinational) |

## Verification
The assertions assume that writes arrive only as single-cycle strobes on the register port. They also assume that reset is held across at least one edge before any access. The stimulus drives every write from the falling clock edge for exactly one cycle. The only write that arrives during a fetch is the deliberately ignored start request. That request lets the check on a stable latched period be exercised without any other source of change.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FINISH
    } fetch_state_e;

    localparam logic [7:0] OFS_CTRL  = 8'h48;
    localparam logic [7:0] OFS_STAT  = 8'h4C;
    localparam logic [7:0] OFS_BADDR = 8'h50;
    localparam logic [7:0] OFS_WIN   = 8'h20;

    localparam int CTRL_START_BIT = 2;
    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_SEC_BIT   = 2;
    localparam int STAT_DONE_BIT  = 4;

    localparam logic [15:0] CTRL_STORE_MASK = 16'hFF3B;
endpackage

// File: rtl/otp_fuse_rom.sv
module otp_fuse_rom #(
    parameter int NUM_BANKS = 8,
    parameter int WORDS     = 4,
    parameter int WORD_W    = 32,
    parameter logic [7:0] SEED = 8'h5A,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(WORDS),
    localparam int BYTES    = WORD_W / 8
) (
    input  logic [BANK_W-1:0] bank_idx,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic              bank_valid,
    output logic [WORD_W-1:0] word_out
);
    logic [31:0] base_byte;

    assign base_byte = (32'(bank_idx) * 32'(WORDS) + 32'(word_idx)) * 32'(BYTES);

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        logic [31:0] byte_addr;
        assign byte_addr = base_byte + 32'(k);
        assign word_out[8*k +: 8] = bank_valid ? (byte_addr[7:0] ^ SEED) : 8'h00;
    end
endmodule

// File: rtl/otp_fetch_fsm.sv
module otp_fetch_fsm
    import otp_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int WORDS     = 4,
    parameter int WORD_W    = 32,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(WORDS),
    localparam int BANK_BITS = WORDS * WORD_W,
    localparam int BANK_LSB = $clog2(BANK_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [31:0]       addr_in,
    input  logic [7:0]        period_in,
    output logic              busy,
    output logic              latch_en,
    output logic [IDX_W-1:0]  latch_idx,
    output logic [BANK_W-1:0] bank_idx,
    output logic              bank_valid,
    output logic              finish,
    output logic [7:0]        period_q
);
    fetch_state_e state_q, state_d;
    logic [7:0]   cnt_q;
    logic         word_end;
    logic         last_word;
    logic         addr_ok;

    assign addr_ok = (addr_in[BANK_LSB-1:0] == '0) &&
                     (addr_in < 32'(NUM_BANKS * BANK_BITS));

    assign word_end  = (state_q == ST_FETCH) && (cnt_q == period_q);
    assign last_word = (latch_idx == IDX_W'(WORDS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = ST_FETCH;
            ST_FETCH:  if (word_end && last_word) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        busy     = 1'b0;
        latch_en = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FETCH:  begin busy = 1'b1; latch_en = word_end; end
            ST_FINISH: begin busy = 1'b1; finish = 1'b1; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            latch_idx  <= '0;
            bank_idx   <= '0;
            bank_valid <= 1'b0;
            period_q   <= '0;
        end else if (state_q == ST_IDLE && launch) begin
            cnt_q      <= '0;
            latch_idx  <= '0;
            bank_idx   <= addr_in[BANK_LSB +: BANK_W];
            bank_valid <= addr_ok;
            period_q   <= period_in;
        end else if (state_q == ST_FETCH) begin
            if (word_end) begin
                cnt_q     <= '0;
                latch_idx <= last_word ? latch_idx : latch_idx + 1'b1;
            end else begin
                cnt_q <= cnt_q + 8'd1;
            end
        end
    end
endmodule

// File: rtl/otp_data_window.sv
module otp_data_window
    import otp_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORDS),
    localparam int STEP  = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic [IDX_W-1:0]  latch_idx,
    input  logic [WORD_W-1:0] latch_word,
    input  logic [7:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] win_q [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                win_q[w] <= '0;
            else if (latch_en && latch_idx == IDX_W'(w))
                win_q[w] <= latch_word;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (rd_addr == 8'(32'(OFS_WIN) + 32'(w * STEP)))
                rd_data = win_q[w];
        end
    end
endmodule

// File: rtl/otp_bank_reader.sv
module otp_bank_reader
    import otp_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int WORDS     = 4,
    parameter int WORD_W    = 32,
    parameter logic [7:0] SEED = 8'h5A,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int IDX_W    = $clog2(WORDS)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [7:0]  reg_wr_addr,
    input  logic [31:0] reg_wr_data,
    input  logic [7:0]  reg_rd_addr,
    output logic [31:0] reg_rd_data,
    input  logic [7:0]  win_rd_addr,
    output logic [31:0] win_rd_data
);
    logic [15:0]       ctrl_q;
    logic              start_q;
    logic              done_q;
    logic              sec_done_q;
    logic [31:0]       baddr_q;
    logic              busy, latch_en, finish, bank_valid;
    logic [IDX_W-1:0]  latch_idx;
    logic [BANK_W-1:0] bank_idx;
    logic [7:0]        period_q;
    logic [WORD_W-1:0] rom_word;
    logic [WORD_W-1:0] win_word;
    logic              launch_wr, launch, clr_done, clr_sec;

    assign launch_wr = reg_wr_en && reg_wr_addr == OFS_CTRL && reg_wr_data[CTRL_START_BIT];
    assign launch    = launch_wr && !busy;
    assign clr_done  = reg_wr_en && reg_wr_addr == OFS_STAT && !reg_wr_data[STAT_DONE_BIT];
    assign clr_sec   = reg_wr_en && reg_wr_addr == OFS_STAT && !reg_wr_data[STAT_SEC_BIT];

    otp_fetch_fsm #(.NUM_BANKS(NUM_BANKS), .WORDS(WORDS), .WORD_W(WORD_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .addr_in(baddr_q),
        .period_in(reg_wr_data[15:8]), .busy(busy), .latch_en(latch_en),
        .latch_idx(latch_idx), .bank_idx(bank_idx), .bank_valid(bank_valid),
        .finish(finish), .period_q(period_q)
    );

    otp_fuse_rom #(.NUM_BANKS(NUM_BANKS), .WORDS(WORDS), .WORD_W(WORD_W), .SEED(SEED)) rom_i (
        .bank_idx(bank_idx), .word_idx(latch_idx), .bank_valid(bank_valid), .word_out(rom_word)
    );

    otp_data_window #(.WORDS(WORDS), .WORD_W(WORD_W)) win_i (
        .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .latch_idx(latch_idx),
        .latch_word(rom_word), .rd_addr(win_rd_addr), .rd_data(win_word)
    );

    assign win_rd_data = 32'(win_word);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            start_q    <= 1'b0;
            done_q     <= 1'b0;
            sec_done_q <= 1'b0;
            baddr_q    <= '0;
        end else begin
            if (reg_wr_en && reg_wr_addr == OFS_CTRL)
                ctrl_q <= reg_wr_data[15:0] & CTRL_STORE_MASK;
            if (finish)      start_q <= 1'b0;
            else if (launch) start_q <= 1'b1;
            if (finish)        done_q <= 1'b1;
            else if (clr_done) done_q <= 1'b0;
            if (clr_sec) sec_done_q <= 1'b0;
            if (reg_wr_en && reg_wr_addr == OFS_BADDR)
                baddr_q <= reg_wr_data;
        end
    end

    always_comb begin
        reg_rd_data = '0;
        unique case (reg_rd_addr)
            OFS_CTRL: begin
                reg_rd_data[15:0] = ctrl_q;
                reg_rd_data[CTRL_START_BIT] = start_q;
            end
            OFS_STAT: begin
                reg_rd_data[STAT_BUSY_BIT] = busy;
                reg_rd_data[STAT_SEC_BIT]  = sec_done_q;
                reg_rd_data[STAT_DONE_BIT] = done_q;
            end
            OFS_BADDR: reg_rd_data = baddr_q;
            default:   reg_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/otp_bank_reader_chk.sv
module otp_bank_reader_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done_q,
    input logic              start_q,
    input logic              finish,
    input logic              launch_wr,
    input logic              clr_done,
    input logic [7:0]        period_q,
    input logic              latch_en,
    input logic              bank_valid,
    input logic [WORD_W-1:0] rom_word
);
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && !clr_done |=> done_q); // R8

    AST_DONE_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> done_q && !busy); // R4

    AST_START_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !start_q); // R4

    AST_BUSY_SHOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> start_q); // R3

    AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && launch_wr && !finish |=> busy && $stable(period_q)); // R5

    AST_BAD_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en && !bank_valid |-> rom_word == '0); // R7
endmodule

bind otp_bank_reader otp_bank_reader_chk #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done_q(done_q), .start_q(start_q),
    .finish(finish), .launch_wr(launch_wr), .clr_done(clr_done), .period_q(period_q),
    .latch_en(latch_en), .bank_valid(bank_valid), .rom_word(rom_word)
);

// File: tb/otp_bank_reader_tb_top.sv
`timescale 1ns/1ps
module otp_bank_reader_tb_top;
    localparam logic [7:0] SEED = 8'h5A;
    localparam logic [7:0] A_CTRL = 8'h48, A_STAT = 8'h4C, A_ADDR = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  wa = '0;
    logic [31:0] wd;
    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    otp_bank_reader dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
        .reg_wr_data(wr_data), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .win_rd_addr(wa), .win_rd_data(wd)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a; #1; d = rd_data;
    endtask

    task automatic rd_win(input logic [7:0] a, output logic [31:0] d);
        wa = a; #1; d = wd;
    endtask

    function automatic logic [31:0] exp_word(input int n, input int w);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'(16*n + 4*w + k) ^ SEED;
        return r;
    endfunction

    // Runs one bank read; inject_k >= 1 sends an extra start request that many cycles in.
    task automatic run_read(input logic [31:0] addr, input int p, input int inject_k,
                            output int cyc, output bit busy_ok);
        logic [31:0] s, c;
        int k;
        do_write(A_STAT, 32'h0);
        do_write(A_ADDR, addr);
        do_write(A_CTRL, {16'h0, 8'(p), 8'h04});
        k = 0; busy_ok = 1'b1;
        forever begin
            @(negedge clk);
            k++;
            wr_en = (k == inject_k);
            wr_addr = A_CTRL; wr_data = 32'h0000_0004;
            rd_reg(A_STAT, s);
            if (s[4]) break;
            rd_reg(A_CTRL, c);
            if (!s[0] || !c[2]) busy_ok = 1'b0;
            if (k > 3000) break;
        end
        @(negedge clk);
        wr_en = 1'b0;
        cyc = k;
    endtask

    initial begin
        #(200000 * 10);
        nerr++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cyc;
        bit bok;
        int periods [4] = '{0, 1, 4, 30};
        logic [31:0] bad [4] = '{32'd1024, 32'd64, 32'd129, 32'hFFFF_FF80};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        rd_reg(A_CTRL, v);  check("R1 ctrl", v, 0);
        rd_reg(A_STAT, v);  check("R1 status", v, 0);
        rd_reg(A_ADDR, v);  check("R1 addr", v, 0);
        for (int w = 0; w < 4; w++) begin
            rd_win(8'(8'h20 + 4*w), v); check("R1 window", v, 0);
        end

        do_write(A_CTRL, 32'hFFFF_FFFB);
        rd_reg(A_CTRL, v);  check("R2 ctrl readback", v, 32'h0000_FF3B);
        @(negedge clk);
        rd_reg(A_STAT, v);  check("R2 no start from storage bits", v, 0);
        do_write(A_CTRL, 32'h0);
        rd_reg(A_CTRL, v);  check("R2 ctrl cleared", v, 0);

        do_write(A_STAT, 32'h14);
        rd_reg(A_STAT, v);  check("R8 software cannot set flags", v, 0);

        foreach (periods[pi]) begin
            for (int n = 0; n < 8; n++) begin
                run_read(32'(n * 128), periods[pi], -1, cyc, bok);
                check("R4 done latency", 32'(cyc), 32'(4 * periods[pi] + 5));
                check("R3 busy and start during fetch", 32'(bok), 1);
                rd_reg(A_STAT, v); check("R4 busy clear, done set", v, 32'h10);
                rd_reg(A_CTRL, v); check("R4 start self-cleared", v, {16'h0, 8'(periods[pi]), 8'h00});
                for (int w = 0; w < 4; w++) begin
                    rd_win(8'(8'h20 + 4*w), v); check("R6 bank word", v, exp_word(n, w));
                end
            end
        end

        rd_win(8'h30, v); check("R9 window beyond last word", v, 0);
        rd_win(8'h21, v); check("R9 window misaligned", v, 0);
        rd_reg(8'h00, v); check("R9 unmapped register", v, 0);

        do_write(A_STAT, 32'h10);
        rd_reg(A_STAT, v); check("R8 write 1 keeps done", v, 32'h10);
        do_write(A_STAT, 32'h0);
        rd_reg(A_STAT, v); check("R8 write 0 clears done", v, 0);

        foreach (bad[bi]) begin
            run_read(32'd640, 0, -1, cyc, bok);
            rd_win(8'h20, v); check("R6 refill before bad read", v, exp_word(5, 0));
            run_read(bad[bi], 2, -1, cyc, bok);
            check("R7 bad address done latency", 32'(cyc), 32'(4 * 2 + 5));
            for (int w = 0; w < 4; w++) begin
                rd_win(8'(8'h20 + 4*w), v); check("R7 bad address zero data", v, 0);
            end
        end

        run_read(32'd384, 3, 2, cyc, bok);
        check("R5 restart ignored, latency kept", 32'(cyc), 32'(4 * 3 + 5));
        check("R5 busy held through ignored start", 32'(bok), 1);
        for (int w = 0; w < 4; w++) begin
            rd_win(8'(8'h20 + 4*w), v); check("R5 data after ignored start", v, exp_word(3, w));
        end
        repeat (3) @(negedge clk);
        rd_reg(A_STAT, v); check("R5 no second fetch", v, 32'h10);

        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule